// File: doc/BRIEF.md
# Pulse Interval Timer

This block measures the time between qualifying transitions on either of two capture inputs. Once the run control is high, a counter advances every system clock. It can instead advance once per filtered rising transition on input 0, which then acts as a slow external count source. Every qualifying transition on an input copies the running count into that input's capture output and restarts the counter from zero. Each capture output therefore holds the length of the most recent interval, and a one-cycle interrupt pulse on the same channel marks the update.

Both inputs pass through a synchroniser and a glitch filter before edge qualification. Each channel has its own 2-bit edge mode, so one input can be used as the trigger while the other is switched off. When the counter runs past its all-ones value it wraps to zero and raises an overflow pulse.

Top module: `pulse_interval_timer`

## Requirements
- R1: While `enable` is 0 the counter is held at zero, and no capture, capture interrupt or overflow interrupt occurs. Capture outputs keep their values.
- R2: With `ext_clk_sel` = 0 the counter advances once per clock. If two qualifying transitions on a channel are N clocks apart, the second one stores N-1 in that channel's capture output.
- R3: A capture clears the counter to zero in the same clock. The channel's interrupt is high for exactly one cycle, in the cycle in which the new capture value first appears.
- R4: Each channel's edge mode is 2 bits: 00 no edge (channel off), 01 rising, 10 falling, 11 both. With 11, the value stored is the length of the phase just ended.
- R5: A level change on an input counts only after the synchronised input has held the new level for 3 consecutive clocks. A pulse of 2 clocks or fewer produces no capture. A pulse of 3 clocks is accepted.
- R6: With `ext_clk_sel` = 1 the counter advances only on each filtered rising transition of `cap_in0`, and channel 0 never captures, whatever its edge mode.
- R7: When the counter advances from all-ones it becomes zero, and `ovf_irq` is high for one cycle.
- R8: When a capture and an advance from all-ones fall in the same clock, the capture stores all-ones, the counter clears, and the capture interrupt and `ovf_irq` rise together.
- R9: Qualifying transitions on both channels in the same clock store the same value in both capture outputs and raise both interrupts in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| enable | input | 1 | Run control; 0 holds the counter at zero |
| ext_clk_sel | input | 1 | 1 selects filtered rising transitions of cap_in0 as the count source |
| edge_sel0 | input | 2 | Edge mode of channel 0 (00 none, 01 rise, 10 fall, 11 both) |
| edge_sel1 | input | 2 | Edge mode of channel 1 (same encoding) |
| cap_in0 | input | 1 | Capture input 0, also the external count source |
| cap_in1 | input | 1 | Capture input 1 |
| cap_val0 | output | CNT_W (16) | Last interval captured on channel 0 |
| cap_val1 | output | CNT_W (16) | Last interval captured on channel 1 |
| cap_irq0 | output | 1 | One-cycle capture pulse, channel 0 |
| cap_irq1 | output | 1 | One-cycle capture pulse, channel 1 |
| ovf_irq | output | 1 | One-cycle counter wrap pulse |

## Verification
Two functions can land in the same clock: a capture on channel 1 and the counter's wrap from all-ones. The bench provokes this by placing two rising transitions on `cap_in1` exactly 65536 clocks apart. Because the filter delay is the same for both transitions, the second capture meets a counter that has just reached all-ones. The bench judges the result by requiring `cap_val1` to read 0xFFFF and by counting a cycle in which `cap_irq1` and `ovf_irq` are high together. A second coincidence, simultaneous captures on both channels, is judged by equal capture values and a shared interrupt cycle.

// File: rtl/pit_pkg.sv
package pit_pkg;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_ANY  = 2'b11
  } edge_mode_e;

  localparam int unsigned NUM_CH = 2;

endpackage

// File: rtl/pit_filter.sv
module pit_filter #(
  parameter int unsigned STABLE = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise_p,
  output logic fall_p
);

  localparam int unsigned CW = (STABLE > 1) ? $clog2(STABLE) : 1;
  localparam logic [CW-1:0] LAST = CW'(STABLE - 1);

  logic [1:0]    sync_q;
  logic          filt_q, filt_d;
  logic [CW-1:0] run_q, run_d;
  logic          diff;

  assign diff = sync_q[1] ^ filt_q;

  // next state: count clocks in which the synchronised input disagrees
  always_comb begin
    filt_d = filt_q;
    run_d  = '0;
    rise_p = 1'b0;
    fall_p = 1'b0;
    if (diff) begin
      if (run_q == LAST) begin
        filt_d = sync_q[1];
        rise_p = sync_q[1];
        fall_p = ~sync_q[1];
      end else begin
        run_d = run_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      filt_q <= 1'b0;
      run_q  <= '0;
    end else begin
      sync_q <= {sync_q[0], din};
      filt_q <= filt_d;
      run_q  <= run_d;
    end
  end

  // R5: an accepted change needs a fresh stable run, so pulses never touch
  a_r5_pulse_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_p || fall_p) |=> !(rise_p || fall_p));

  // R5: an edge is only issued after the disagreement persisted
  a_r5_needs_history: assert property (@(posedge clk) disable iff (!rst_n)
    rise_p |-> $past(sync_q[1]));

endmodule

// File: rtl/pit_counter.sv
module pit_counter #(
  parameter int unsigned W   = 16,
  parameter int unsigned NCH = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  run,
  input  logic                  tick,
  input  logic [NCH-1:0]        cap_ev,
  output logic [NCH-1:0][W-1:0] cap_val,
  output logic [NCH-1:0]        cap_irq,
  output logic                  ovf_irq
);

  logic [W-1:0]          cnt_q, cnt_d;
  logic [NCH-1:0][W-1:0] capv_q, capv_d;
  logic [NCH-1:0]        irq_q, irq_d;
  logic                  ovf_q, ovf_d;
  logic                  at_top;

  assign at_top = (cnt_q == '1);

  always_comb begin
    cnt_d  = cnt_q;
    capv_d = capv_q;
    irq_d  = '0;
    ovf_d  = 1'b0;
    if (!run) begin
      cnt_d = '0;
    end else begin
      ovf_d = tick && at_top;
      if (|cap_ev) begin
        cnt_d = '0;
      end else if (tick) begin
        cnt_d = cnt_q + 1'b1;
      end
      for (int c = 0; c < NCH; c++) begin
        if (cap_ev[c]) begin
          capv_d[c] = cnt_q;
          irq_d[c]  = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      capv_q <= '0;
      irq_q  <= '0;
      ovf_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      capv_q <= capv_d;
      irq_q  <= irq_d;
      ovf_q  <= ovf_d;
    end
  end

  assign cap_val = capv_q;
  assign cap_irq = irq_q;
  assign ovf_irq = ovf_q;

  // R1: stopped timer stays cleared and silent
  a_r1_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0 && irq_q == '0 && !ovf_q));

  // R1: capture registers only move on an interrupt
  a_r1_hold_caps: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q == '0) |-> $stable(capv_q));

  // R3: every capture restarts the count
  a_r3_clear_on_cap: assert property (@(posedge clk) disable iff (!rst_n)
    (run && |cap_ev) |=> cnt_q == '0);

  // R7: an overflow pulse always leaves the counter at zero
  a_r7_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |-> cnt_q == '0);

  // R8: coincident capture and wrap keep both interrupts
  a_r8_cap_and_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && at_top && |cap_ev) |=> (ovf_q && |irq_q));

endmodule

// File: rtl/pulse_interval_timer.sv
module pulse_interval_timer #(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned FILT_LEN = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             ext_clk_sel,
  input  logic [1:0]       edge_sel0,
  input  logic [1:0]       edge_sel1,
  input  logic             cap_in0,
  input  logic             cap_in1,
  output logic [CNT_W-1:0] cap_val0,
  output logic [CNT_W-1:0] cap_val1,
  output logic             cap_irq0,
  output logic             cap_irq1,
  output logic             ovf_irq
);
  import pit_pkg::*;

  localparam int unsigned NCH = NUM_CH;

  logic [1:0]                rst_sync_q;
  logic                      rst_int_n;
  logic [NCH-1:0]            raw, rise, fall, hit, cap_ev, irq;
  edge_mode_e                mode [NCH];
  logic [NCH-1:0][CNT_W-1:0] capv;
  logic                      tick;

  // reset: assert at once, leave on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign raw     = {cap_in1, cap_in0};
  assign mode[0] = edge_mode_e'(edge_sel0);
  assign mode[1] = edge_mode_e'(edge_sel1);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam bit CLK_SRC = (c == 0);

    pit_filter #(.STABLE(FILT_LEN)) u_filt (
      .clk    (clk),
      .rst_n  (rst_int_n),
      .din    (raw[c]),
      .rise_p (rise[c]),
      .fall_p (fall[c])
    );

    always_comb begin
      unique case (mode[c])
        EDGE_RISE: hit[c] = rise[c];
        EDGE_FALL: hit[c] = fall[c];
        EDGE_ANY:  hit[c] = rise[c] | fall[c];
        default:   hit[c] = 1'b0;
      endcase
    end

    assign cap_ev[c] = enable & hit[c] & ~(CLK_SRC & ext_clk_sel);
  end

  assign tick = ext_clk_sel ? rise[0] : 1'b1;

  pit_counter #(.W(CNT_W), .NCH(NCH)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .run     (enable),
    .tick    (tick),
    .cap_ev  (cap_ev),
    .cap_val (capv),
    .cap_irq (irq),
    .ovf_irq (ovf_irq)
  );

  assign cap_val0 = capv[0];
  assign cap_val1 = capv[1];
  assign cap_irq0 = irq[0];
  assign cap_irq1 = irq[1];

  // R6: input 0 is a count source only, never a trigger
  a_r6_no_cap0_ext: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ext_clk_sel && $past(ext_clk_sel)) |-> !cap_irq0);

  // R3: capture interrupts are single-cycle pulses
  a_r3_irq1_pulse: assert property (@(posedge clk) disable iff (!rst_int_n)
    cap_irq1 |=> !cap_irq1);

  // R4: a switched-off channel raises nothing
  a_r4_off_silent: assert property (@(posedge clk) disable iff (!rst_int_n)
    (edge_sel1 == 2'b00) |=> !cap_irq1);

endmodule

// File: tb/pulse_interval_timer_bench.sv
module pulse_interval_timer_bench;

  localparam int CLK_P    = 10;
  localparam int WD_LIMIT = 150000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        enable, ext_clk_sel;
  logic [1:0]  edge_sel0, edge_sel1;
  logic        cap_in0, cap_in1;
  logic [15:0] cap_val0, cap_val1;
  logic        cap_irq0, cap_irq1, ovf_irq;
  logic [7:0]  s_val0, s_val1;
  logic        s_irq0, s_irq1, s_ovf;

  always #(CLK_P/2) clk = ~clk;

  pulse_interval_timer u_pulse_interval_timer (
    .clk(clk), .rst_n(rst_n), .enable(enable), .ext_clk_sel(ext_clk_sel),
    .edge_sel0(edge_sel0), .edge_sel1(edge_sel1),
    .cap_in0(cap_in0), .cap_in1(cap_in1),
    .cap_val0(cap_val0), .cap_val1(cap_val1),
    .cap_irq0(cap_irq0), .cap_irq1(cap_irq1), .ovf_irq(ovf_irq)
  );

  pulse_interval_timer #(.CNT_W(8)) u_pulse_interval_timer_w8 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .ext_clk_sel(ext_clk_sel),
    .edge_sel0(edge_sel0), .edge_sel1(edge_sel1),
    .cap_in0(cap_in0), .cap_in1(cap_in1),
    .cap_val0(s_val0), .cap_val1(s_val1),
    .cap_irq0(s_irq0), .cap_irq1(s_irq1), .ovf_irq(s_ovf)
  );

  // event monitor, sampled at the falling edge
  int n_irq0 = 0, n_irq1 = 0, n_ovf = 0, n_both = 0, n_ovf_cap1 = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      n_irq0 <= n_irq0 + int'(cap_irq0);
      n_irq1 <= n_irq1 + int'(cap_irq1);
      n_ovf  <= n_ovf + int'(ovf_irq);
      n_both <= n_both + int'(cap_irq0 && cap_irq1);
      n_ovf_cap1 <= n_ovf_cap1 + int'(ovf_irq && cap_irq1);
    end
  end

  // {channel, mode, high clocks, low clocks}
  localparam logic [18:0] VEC [8] = '{
    {1'b1, 2'b01, 8'd5,   8'd7},
    {1'b1, 2'b10, 8'd4,   8'd9},
    {1'b1, 2'b11, 8'd6,   8'd10},
    {1'b1, 2'b00, 8'd5,   8'd5},
    {1'b0, 2'b01, 8'd20,  8'd13},
    {1'b0, 2'b10, 8'd4,   8'd4},
    {1'b0, 2'b11, 8'd12,  8'd5},
    {1'b1, 2'b01, 8'd100, 8'd150}
  };

  int total = 0, bad = 0;

  task automatic wcyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_in(input bit ch, input logic v);
    if (ch) cap_in1 = v; else cap_in0 = v;
  endtask

  task automatic run_vec(input logic [18:0] v);
    bit         ch   = v[18];
    logic [1:0] m    = v[17:16];
    int         hi   = int'(v[15:8]);
    int         lo   = int'(v[7:0]);
    int         base, prev, got, exp_n, exp_v;
    ext_clk_sel = 1'b0;
    enable      = 1'b1;
    edge_sel0   = ch ? 2'b00 : m;
    edge_sel1   = ch ? m : 2'b00;
    wcyc(6);
    prev = ch ? int'(cap_val1) : int'(cap_val0);
    base = ch ? n_irq1 : n_irq0;
    for (int k = 0; k < 3; k++) begin
      set_in(ch, 1'b1); wcyc(hi);
      set_in(ch, 1'b0); wcyc(lo);
    end
    set_in(ch, 1'b1);
    wcyc(8);
    case (m)
      2'b01:   begin exp_n = 4; exp_v = hi + lo - 1; end
      2'b10:   begin exp_n = 3; exp_v = hi + lo - 1; end
      2'b11:   begin exp_n = 7; exp_v = lo - 1; end
      default: begin exp_n = 0; exp_v = prev; end
    endcase
    got = ch ? n_irq1 - base : n_irq0 - base;
    check(got == exp_n, "R4 capture count", got, exp_n);
    got = ch ? int'(cap_val1) : int'(cap_val0);
    check(got == exp_v, "R2 interval value", got, exp_v);
    edge_sel0 = 2'b00;
    edge_sel1 = 2'b00;
    set_in(ch, 1'b0);
    wcyc(8);
  endtask

  task automatic run_all;
    int base, base2, prev;
    // reset state (R1)
    wcyc(4);
    check(cap_val0 == 16'h0, "R1 reset cap_val0", int'(cap_val0), 0);
    check(cap_val1 == 16'h0, "R1 reset cap_val1", int'(cap_val1), 0);
    check({cap_irq0, cap_irq1, ovf_irq} == 3'b000, "R1 reset irqs",
          int'({cap_irq0, cap_irq1, ovf_irq}), 0);

    // table walk (R2, R3, R4)
    for (int i = 0; i < 8; i++) run_vec(VEC[i]);

    // R1: stopped timer ignores transitions
    enable = 1'b0; edge_sel1 = 2'b01;
    wcyc(3);
    prev = int'(cap_val1); base = n_irq1; base2 = n_ovf;
    for (int k = 0; k < 3; k++) begin
      cap_in1 = 1'b1; wcyc(5); cap_in1 = 1'b0; wcyc(5);
    end
    wcyc(6);
    check(n_irq1 == base, "R1 no capture while stopped", n_irq1 - base, 0);
    check(int'(cap_val1) == prev, "R1 value held while stopped", int'(cap_val1), prev);
    check(n_ovf == base2, "R1 no overflow while stopped", n_ovf - base2, 0);

    // R5: glitch filter boundary
    enable = 1'b1; edge_sel1 = 2'b11;
    wcyc(4);
    base = n_irq1;
    cap_in1 = 1'b1; wcyc(2); cap_in1 = 1'b0; wcyc(10);
    check(n_irq1 == base, "R5 two-clock pulse dropped", n_irq1 - base, 0);
    cap_in1 = 1'b1; wcyc(3); cap_in1 = 1'b0; wcyc(10);
    check(n_irq1 - base == 2, "R5 three-clock pulse kept", n_irq1 - base, 2);
    check(cap_val1 == 16'd2, "R5 pulse width value", int'(cap_val1), 2);
    edge_sel1 = 2'b00;

    // R9: both channels in the same clock
    edge_sel0 = 2'b01; edge_sel1 = 2'b01;
    wcyc(2);
    base = n_both;
    cap_in0 = 1'b1; cap_in1 = 1'b1; wcyc(5);
    cap_in0 = 1'b0; cap_in1 = 1'b0; wcyc(25);
    cap_in0 = 1'b1; cap_in1 = 1'b1; wcyc(8);
    check(cap_val0 == 16'd29, "R9 channel 0 value", int'(cap_val0), 29);
    check(cap_val1 == 16'd29, "R9 channel 1 value", int'(cap_val1), 29);
    check(n_both - base == 2, "R9 shared interrupt cycles", n_both - base, 2);
    cap_in0 = 1'b0; cap_in1 = 1'b0;
    edge_sel0 = 2'b00; edge_sel1 = 2'b00;
    wcyc(8);

    // R6: external count source on input 0
    ext_clk_sel = 1'b1; edge_sel0 = 2'b01; edge_sel1 = 2'b01;
    wcyc(2);
    base = n_irq0; base2 = n_irq1;
    for (int k = 0; k < 11; k++) begin
      cap_in0 = 1'b1; wcyc(5);
      cap_in0 = 1'b0; wcyc(2);
      if (k == 2 || k == 8) cap_in1 = 1'b1;
      if (k == 4) cap_in1 = 1'b0;
      wcyc(3);
    end
    wcyc(6);
    check(cap_val1 == 16'd6, "R6 external ticks counted", int'(cap_val1), 6);
    check(n_irq1 - base2 == 2, "R6 channel 1 captures", n_irq1 - base2, 2);
    check(n_irq0 == base, "R6 channel 0 suppressed", n_irq0 - base, 0);
    cap_in1 = 1'b0; ext_clk_sel = 1'b0;
    edge_sel0 = 2'b00; edge_sel1 = 2'b00;
    wcyc(8);

    // R7: wrap of the 8-bit instance
    enable = 1'b0; wcyc(3);
    enable = 1'b1;
    wcyc(255);
    check(s_ovf == 1'b0, "R7 no wrap before top", int'(s_ovf), 0);
    wcyc(1);
    check(s_ovf == 1'b1, "R7 wrap pulse", int'(s_ovf), 1);
    wcyc(1);
    check(s_ovf == 1'b0, "R7 wrap pulse one cycle", int'(s_ovf), 0);

    // R8: capture and wrap together on the 16-bit instance
    edge_sel1 = 2'b01;
    wcyc(2);
    base = n_ovf; base2 = n_ovf_cap1;
    cap_in1 = 1'b1; wcyc(8);
    cap_in1 = 1'b0; wcyc(65536 - 8);
    cap_in1 = 1'b1; wcyc(8);
    check(cap_val1 == 16'hFFFF, "R8 all-ones captured", int'(cap_val1), 16'hFFFF);
    check(n_ovf_cap1 - base2 == 1, "R8 interrupts together", n_ovf_cap1 - base2, 1);
    check(n_ovf - base == 1, "R8 single overflow", n_ovf - base, 1);
    cap_in1 = 1'b0;
    wcyc(8);
  endtask

  initial begin
    bit wd = 1'b0;
    rst_n = 1'b0; enable = 1'b0; ext_clk_sel = 1'b0;
    edge_sel0 = 2'b00; edge_sel1 = 2'b00;
    cap_in0 = 1'b0; cap_in1 = 1'b0;
    wcyc(4);
    rst_n = 1'b1;
    fork
      run_all();
      begin repeat (WD_LIMIT) @(posedge clk); wd = 1'b1; end
    join_any
    disable fork;
    if (wd) check(1'b0, "watchdog expired", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule